// File: doc/BRIEF.md
# Minimum Sample Window Duty Adjuster

This block prepares the three phase compare values of a center-aligned PWM period so that a single DC-link current shunt can be sampled during both active vectors. On a `start` pulse it captures the three compare values, the period, a minimum window length and an ADC trigger delay. It ranks the phases into highest, middle and lowest compare value. The two active-vector intervals are the gap between the highest and the middle value and the gap between the middle and the lowest value.

An interval that is too short is widened for the rising (first) half of the period. The highest phase is raised, or the lowest phase is lowered, until the gap equals the minimum window. The falling (second) half gets the mirror shift, so each phase's first-half and second-half values still add up to twice its requested value. The middle phase is never moved. Two ADC trigger times are produced, one for each active vector. All results are clamped to the range 0 to the period. A `done` pulse marks the cycle in which a new result appears on the outputs.

Top module: `min_window_adjuster`

## Requirements
- R1: While `rst_n` is low, all compare and trigger outputs are 0 and `done` is 0.
- R2: A `start` sampled high at a clock edge gives a one-cycle `done` pulse after the third edge from and including that one. The outputs take their new values in that same cycle and hold them until the next `done`.
- R3: Phases are ranked by compare value. When two values are equal, A ranks above B and B ranks above C, so with equal values the earlier phase is treated as the higher one.
- R4: If both gaps (highest minus middle, middle minus lowest) are at least `t_sample`, every first-half and second-half output equals the phase's input compare value.
- R5: If the upper gap is below `t_sample`, the highest phase's first-half value becomes middle + `t_sample`. The middle phase's outputs stay equal to its input.
- R6: If the lower gap is below `t_sample`, the lowest phase's first-half value becomes middle − `t_sample`.
- R7: The second-half value of each moved phase is twice its input minus its first-half value, so first-half plus second-half equals twice the input whenever no clamping applies.
- R8: Every first-half, second-half and trigger value is clamped to the range 0 to `period`, with no wraparound.
- R9: `trig_lo` = middle − `t_sample`/2 + `t_delay`, and `trig_hi` = (adjusted highest first-half value) − `t_sample`/2 + `t_delay`. The division truncates, and both results are clamped as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture inputs and begin one adjustment |
| cmp_a | input | W | Requested compare value, phase A |
| cmp_b | input | W | Requested compare value, phase B |
| cmp_c | input | W | Requested compare value, phase C |
| period | input | W | PWM half-period count (upper clamp) |
| t_sample | input | W | Minimum active-vector window |
| t_delay | input | W | ADC trigger delay |
| up_a | output | W | First-half compare, phase A |
| up_b | output | W | First-half compare, phase B |
| up_c | output | W | First-half compare, phase C |
| dn_a | output | W | Second-half compare, phase A |
| dn_b | output | W | Second-half compare, phase B |
| dn_c | output | W | Second-half compare, phase C |
| trig_lo | output | W | ADC trigger for the lower active vector |
| trig_hi | output | W | ADC trigger for the upper active vector |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
All results of one request come from a three-register pipeline. A `start` sampled at one edge therefore yields `done` and all eight values after the second edge that follows it, and those values must hold until the next result. The bench records every accepted `start` with the edge count at which its result is due. Between edges, it compares `done` and every output against a queue-fed reference. This catches early, late and missing results, and it also catches outputs that change while they should hold. Back-to-back starts check that the pipeline keeps requests apart.

// File: rtl/min_window_adjuster.sv
module min_window_adjuster #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic [W-1:0] cmp_c,
  input  logic [W-1:0] period,
  input  logic [W-1:0] t_sample,
  input  logic [W-1:0] t_delay,
  output logic [W-1:0] up_a,
  output logic [W-1:0] up_b,
  output logic [W-1:0] up_c,
  output logic [W-1:0] dn_a,
  output logic [W-1:0] dn_b,
  output logic [W-1:0] dn_c,
  output logic [W-1:0] trig_lo,
  output logic [W-1:0] trig_hi,
  output logic         done
);
  localparam int S = W + 3;

  // capture stage
  logic         v0;
  logic [W-1:0] c0 [3];
  logic [W-1:0] per0, ts0, td0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v0 <= 1'b0;
      for (int i = 0; i < 3; i++) c0[i] <= '0;
      per0 <= '0; ts0 <= '0; td0 <= '0;
    end else begin
      v0 <= start;
      if (start) begin
        c0[0] <= cmp_a; c0[1] <= cmp_b; c0[2] <= cmp_c;
        per0 <= period; ts0 <= t_sample; td0 <= t_delay;
      end
    end

  // rank stage: ties resolved A over B over C
  wire ab = c0[0] >= c0[1];
  wire ac = c0[0] >= c0[2];
  wire bc = c0[1] >= c0[2];
  wire [1:0] rk_max = (ab && ac) ? 2'd0 : (!ab && bc) ? 2'd1 : 2'd2;
  wire [1:0] rk_min = (!ab && !ac) ? 2'd0 : (ab && !bc) ? 2'd1 : 2'd2;
  wire [1:0] rk_mid = 2'd3 - rk_max - rk_min;

  logic         v1;
  logic [1:0]   imax, imin;
  logic [W-1:0] vmax, vmid, vmin, per1, ts1, td1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1 <= 1'b0; imax <= 2'd0; imin <= 2'd2;
      vmax <= '0; vmid <= '0; vmin <= '0;
      per1 <= '0; ts1 <= '0; td1 <= '0;
    end else begin
      v1 <= v0;
      if (v0) begin
        imax <= rk_max; imin <= rk_min;
        vmax <= c0[rk_max]; vmid <= c0[rk_mid]; vmin <= c0[rk_min];
        per1 <= per0; ts1 <= ts0; td1 <= td0;
      end
    end

  // adjust stage
  function automatic logic [W-1:0] clampw(input logic signed [S-1:0] x,
                                          input logic [W-1:0] lim);
    logic signed [S-1:0] l;
    l = $signed({3'b000, lim});
    if (x < 0)      return '0;
    else if (x > l) return lim;
    else            return x[W-1:0];
  endfunction

  wire signed [S-1:0] smax = $signed({3'b000, vmax});
  wire signed [S-1:0] smid = $signed({3'b000, vmid});
  wire signed [S-1:0] smin = $signed({3'b000, vmin});
  wire signed [S-1:0] sts  = $signed({3'b000, ts1});
  wire signed [S-1:0] sper = $signed({3'b000, per1});
  wire signed [S-1:0] shts = $signed({4'b0000, ts1[W-1:1]});
  wire signed [S-1:0] std  = $signed({3'b000, td1});

  wire signed [S-1:0] hi_raw = smid + sts;
  wire signed [S-1:0] lo_raw = smid - sts;
  wire signed [S-1:0] hi_w   = (hi_raw > smax) ? hi_raw : smax;
  wire signed [S-1:0] lo_w   = (lo_raw < smin) ? lo_raw : smin;
  wire signed [S-1:0] hi_c   = (hi_w > sper) ? sper : hi_w;
  wire signed [S-1:0] lo_c   = (lo_w < 0) ? '0 : lo_w;

  wire [W-1:0] n_hi_up = clampw(hi_c, per1);
  wire [W-1:0] n_lo_up = clampw(lo_c, per1);
  wire [W-1:0] n_hi_dn = clampw((smax <<< 1) - hi_c, per1);
  wire [W-1:0] n_lo_dn = clampw((smin <<< 1) - lo_c, per1);
  wire [W-1:0] n_tlo   = clampw(smid - shts + std, per1);
  wire [W-1:0] n_thi   = clampw(hi_c - shts + std, per1);

  logic [W-1:0] up_q [3];
  logic [W-1:0] dn_q [3];

  for (genvar p = 0; p < 3; p++) begin : g_ph
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        up_q[p] <= '0; dn_q[p] <= '0;
      end else if (v1) begin
        if (imax == p[1:0])      begin up_q[p] <= n_hi_up; dn_q[p] <= n_hi_dn; end
        else if (imin == p[1:0]) begin up_q[p] <= n_lo_up; dn_q[p] <= n_lo_dn; end
        else begin
          up_q[p] <= clampw(smid, per1); dn_q[p] <= clampw(smid, per1);
        end
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done <= 1'b0; trig_lo <= '0; trig_hi <= '0;
    end else begin
      done <= v1;
      if (v1) begin trig_lo <= n_tlo; trig_hi <= n_thi; end
    end

  assign up_a = up_q[0]; assign up_b = up_q[1]; assign up_c = up_q[2];
  assign dn_a = dn_q[0]; assign dn_b = dn_q[1]; assign dn_c = dn_q[2];
endmodule

module min_window_adjuster_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic [W-1:0] period,
  input logic [W-1:0] up_a,
  input logic [W-1:0] up_b,
  input logic [W-1:0] up_c,
  input logic [W-1:0] dn_a,
  input logic [W-1:0] dn_b,
  input logic [W-1:0] dn_c,
  input logic [W-1:0] trig_lo,
  input logic [W-1:0] trig_hi
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !done);
  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 3));
  // R2
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(up_a) && $stable(dn_c) && $stable(trig_hi));
  // R8
  up_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> up_a <= $past(period, 3) && up_b <= $past(period, 3) && up_c <= $past(period, 3));
  // R8
  dn_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> dn_a <= $past(period, 3) && dn_b <= $past(period, 3) && dn_c <= $past(period, 3));
  // R8
  trig_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> trig_lo <= $past(period, 3) && trig_hi <= $past(period, 3));
endmodule

bind min_window_adjuster min_window_adjuster_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .period(period),
  .up_a(up_a), .up_b(up_b), .up_c(up_c), .dn_a(dn_a), .dn_b(dn_b), .dn_c(dn_c),
  .trig_lo(trig_lo), .trig_hi(trig_hi));

// File: tb/min_window_adjuster_tb.sv
module min_window_adjuster_tb;
  localparam int W = 12;
  logic clk = 0, rst_n = 0, start = 0;
  logic [W-1:0] cmp_a = 0, cmp_b = 0, cmp_c = 0, period = 0, t_sample = 0, t_delay = 0;
  logic [W-1:0] up_a, up_b, up_c, dn_a, dn_b, dn_c, trig_lo, trig_hi;
  logic done;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  min_window_adjuster #(.W(W)) u_dut (.*);

  int    due_q[$];
  int    exp_q[$];
  string tag_q[$];
  int    cur[8];
  string cur_tag = "R1";
  string stim_tag = "R4";

  function automatic int lim(int x, int p);
    return (x < 0) ? 0 : (x > p) ? p : x;
  endfunction

  task automatic push_model();
    int v[3], ord[3], res[8], hi, lo, mid, t;
    v[0] = cmp_a; v[1] = cmp_b; v[2] = cmp_c;
    ord[0] = 0; ord[1] = 1; ord[2] = 2;
    for (int pass = 0; pass < 2; pass++)
      for (int j = 0; j < 2; j++)
        if (v[ord[j+1]] > v[ord[j]]) begin t = ord[j]; ord[j] = ord[j+1]; ord[j+1] = t; end
    mid = v[ord[1]];
    hi = v[ord[0]]; if (mid + t_sample > hi) hi = mid + t_sample; if (hi > period) hi = period;
    lo = v[ord[2]]; if (mid - int'(t_sample) < lo) lo = mid - t_sample; if (lo < 0) lo = 0;
    res[ord[0]]   = lim(hi, period);  res[3+ord[0]] = lim(2*v[ord[0]] - hi, period);
    res[ord[2]]   = lim(lo, period);  res[3+ord[2]] = lim(2*v[ord[2]] - lo, period);
    res[ord[1]]   = lim(mid, period); res[3+ord[1]] = lim(mid, period);
    res[6] = lim(mid - t_sample/2 + t_delay, period);
    res[7] = lim(hi - t_sample/2 + t_delay, period);
    for (int k = 0; k < 8; k++) exp_q.push_back(res[k]);
    due_q.push_back(cyc + 2);
    tag_q.push_back(stim_tag);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      due_q.delete(); exp_q.delete(); tag_q.delete();
    end else if (start) begin
      cyc = cyc + 1;
      push_model();
      cyc = cyc - 1;
    end
  end

  task automatic chk(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d (cycle %0d)", tag, nm, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    logic exp_done;
    exp_done = 0;
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) cur[k] = 0;
      cur_tag = "R1";
    end else if (due_q.size() > 0 && due_q[0] == cyc) begin
      void'(due_q.pop_front());
      for (int k = 0; k < 8; k++) cur[k] = exp_q.pop_front();
      cur_tag = tag_q.pop_front();
      exp_done = 1;
    end
    chk(rst_n ? "R2" : "R1", "done", done, exp_done);
    chk(cur_tag, "up_a", up_a, cur[0]);
    chk(cur_tag, "up_b", up_b, cur[1]);
    chk(cur_tag, "up_c", up_c, cur[2]);
    chk(rst_n ? "R7" : "R1", "dn_a", dn_a, cur[3]);
    chk(rst_n ? "R7" : "R1", "dn_b", dn_b, cur[4]);
    chk(rst_n ? "R7" : "R1", "dn_c", dn_c, cur[5]);
    chk(rst_n ? "R9" : "R1", "trig_lo", trig_lo, cur[6]);
    chk(rst_n ? "R9" : "R1", "trig_hi", trig_hi, cur[7]);
  end

  task automatic go(string tg, int a, int b, int c, int gap);
    @(posedge clk); #1;
    stim_tag = tg; cmp_a = W'(a); cmp_b = W'(b); cmp_c = W'(c); start = 1;
    @(posedge clk); #1;
    start = 0;
    repeat (gap) @(posedge clk);
  endtask

  initial begin
    period = 1000; t_sample = 100; t_delay = 20;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    go("R4", 700, 500, 200, 4);   // both gaps wide: unchanged
    go("R5", 550, 500, 200, 4);   // upper gap short
    go("R6", 800, 500, 450, 4);   // lower gap short
    go("R3", 500, 500, 500, 4);   // full tie: A high, C low
    go("R3", 300, 600, 600, 4);   // B above C on tie
    go("R3", 600, 600, 100, 4);   // A above B on tie
    go("R8", 980, 950, 20, 4);    // high side clamps at period
    go("R8", 900, 60, 30, 4);     // low side clamps at 0
    t_delay = 990;
    go("R9", 700, 500, 200, 4);   // triggers clamp at period
    t_delay = 0; t_sample = 101;
    go("R9", 520, 500, 480, 4);   // odd window, truncated half
    t_sample = 100; t_delay = 20;
    go("R2", 100, 200, 300, 0);   // back-to-back
    go("R2", 300, 200, 100, 0);
    go("R2", 250, 260, 270, 4);
    for (int i = 0; i < 40; i++) begin
      t_sample = W'($urandom_range(0, 200));
      t_delay  = W'($urandom_range(0, 100));
      go("R5", $urandom_range(0, 1000), $urandom_range(0, 1000), $urandom_range(0, 1000),
         $urandom_range(0, 3));
    end
    repeat (6) @(posedge clk);
    #1 rst_n = 0;                 // reset clears outputs
    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule